// File: doc/BRIEF.md
# Little-Endian Load Data Extractor

This block sits behind a load port whose memory returns one naturally aligned 64-bit word per request. A request carries the 32-bit byte address, an explicit two-bit size code and a valid strobe. The low three address bits pick the starting byte lane inside the memory word. The block then collects one, two, four or eight lanes in little-endian order and right-justifies them. Narrow results are zero-extended into the 32-bit destination.

A doubleword load fills a register pair. The lower four bytes go to the even register through `rsp_lo`, and the upper four go to the odd register through `rsp_hi`. A request that is not aligned to its own size returns zeros with an error flag. Results appear one clock after the request. The result registers keep their contents while no request is presented.

Top module: `lx_load_extract`

## Requirements
- R1: While `rst_n` is low, and after it is released, `rsp_valid`, `rsp_err`, `rsp_lo` and `rsp_hi` are all zero until the first request. Assertion of `rst_n` clears them without waiting for a clock edge.
- R2: `rsp_valid` is high in exactly the cycle after a cycle in which `req_valid` was high, giving one cycle of latency.
- R3: Byte lane k of `mem_data` is bits [8k+7:8k] and holds the byte whose address has `req_addr[2:0]` equal to k. Size code 0 (byte) returns that lane in `rsp_lo[7:0]` with `rsp_lo[31:8]` zero; with byte 0x01 at address 4, a byte load from 4 returns 0x00000001.
- R4: Size code 1 (halfword) returns lanes off and off+1, with the lower address in bits [7:0], zero-extended to 32 bits. With bytes 0x01 and 0x02 at addresses 4 and 5, the result is 0x00000201.
- R5: Size code 2 (word) returns four lanes starting at off, with the lowest address in bits [7:0]. Bytes 0x01 to 0x04 at addresses 4 to 7 give 0x04030201.
- R6: Size code 3 (doubleword) returns lanes 0 to 3 in `rsp_lo` and lanes 4 to 7 in `rsp_hi`. Bytes 0x01 to 0x08 at addresses 8 to 15 give `rsp_hi` 0x08070605 and `rsp_lo` 0x04030201.
- R7: For size codes 0, 1 and 2, `rsp_hi` is zero.
- R8: A request whose `req_addr[2:0]` is not a multiple of the access size in bytes returns `rsp_err` high with `rsp_lo` and `rsp_hi` zero. An aligned request returns `rsp_err` low.
- R9: In a cycle following one without `req_valid`, `rsp_valid` is low and `rsp_lo`, `rsp_hi` and `rsp_err` keep their previous values. Address, size and memory data presented without `req_valid` have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | A load request is present this cycle |
| req_addr | input | 32 | Byte address of the load |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 doubleword |
| mem_data | input | 64 | Aligned memory word containing the addressed bytes |
| rsp_valid | output | 1 | Result registers were loaded by a request last cycle |
| rsp_lo | output | 32 | Result, or even register of a doubleword pair |
| rsp_hi | output | 32 | Odd register of a doubleword pair, zero otherwise |
| rsp_err | output | 1 | Last request was misaligned for its size |

## Verification
The bench builds the block with its default parameters: a 32-bit address and a 64-bit memory word, which gives eight byte lanes and a three-bit lane offset. At that width, every combination of size and lane offset can be reached. This includes all seven misaligned offsets of a doubleword and the odd offsets of halfwords. The bench applies each combination both with and without the valid strobe, over varied memory words. Directed vectors reproduce the little-endian examples for each size and an asynchronous reset in the middle of a run.

// File: rtl/lx_pkg.sv
package lx_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_DBL  = 2'd3
  } lx_size_e;
endpackage

// File: rtl/lx_rst_sync.sv
module lx_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_sync_n <= stage_q;
    end
  end
endmodule

// File: rtl/lx_align_chk.sv
module lx_align_chk #(
  parameter int OFF_W = 3
) (
  input  logic [OFF_W-1:0] off_i,
  input  logic [1:0]       size_i,
  output logic             misalign_o
);
  logic [OFF_W-1:0] low_mask;

  // Offset bits below log2(size in bytes) must be zero.
  always_comb begin
    for (int b = 0; b < OFF_W; b++) begin
      low_mask[b] = (b < int'(size_i));
    end
    misalign_o = |(off_i & low_mask);
  end
endmodule

// File: rtl/lx_lane_sel.sv
module lx_lane_sel #(
  parameter int BYTES = 8,
  parameter int OFF_W = 3
) (
  input  logic [8*BYTES-1:0] data_i,
  input  logic [OFF_W-1:0]   off_i,
  output logic [8*BYTES-1:0] data_o
);
  // Output byte j takes input lane j+off; lanes past the top read as zero.
  for (genvar j = 0; j < BYTES; j++) begin : g_lane
    logic [7:0] pick;
    always_comb begin
      pick = 8'h00;
      for (int k = 0; k < BYTES; k++) begin
        if (int'(off_i) + j == k) begin
          pick = data_i[8*k +: 8];
        end
      end
    end
    assign data_o[8*j +: 8] = pick;
  end
endmodule

// File: rtl/lx_size_mask.sv
module lx_size_mask #(
  parameter int BYTES = 8
) (
  input  logic [8*BYTES-1:0] data_i,
  input  logic [1:0]         size_i,
  input  logic               err_i,
  output logic [8*BYTES-1:0] data_o
);
  int keep;

  always_comb begin
    keep = 1 << int'(size_i);
  end

  // Bytes above the access size are zero-filled; an error zeroes everything.
  for (genvar j = 0; j < BYTES; j++) begin : g_byte
    assign data_o[8*j +: 8] = (!err_i && (j < keep)) ? data_i[8*j +: 8] : 8'h00;
  end
endmodule

// File: rtl/lx_load_extract.sv
module lx_load_extract #(
  parameter int ADDR_W = 32,
  parameter int MEM_W  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic [MEM_W-1:0]  mem_data,
  output logic              rsp_valid,
  output logic [MEM_W/2-1:0] rsp_lo,
  output logic [MEM_W/2-1:0] rsp_hi,
  output logic              rsp_err
);
  import lx_pkg::*;

  localparam int BYTES = MEM_W / 8;
  localparam int OFF_W = $clog2(BYTES);
  localparam int REG_W = MEM_W / 2;

  logic              rst_sync_n;
  logic [OFF_W-1:0]  lane_off;
  logic              misalign;
  logic [MEM_W-1:0]  shifted;
  logic [MEM_W-1:0]  justified;
  logic              addr_hi_unused;

  logic              valid_d;
  logic              load_en;
  logic [REG_W-1:0]  lo_d, hi_d;
  logic              err_d;

  assign lane_off       = req_addr[OFF_W-1:0];
  assign addr_hi_unused = ^req_addr[ADDR_W-1:OFF_W];

  lx_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  lx_align_chk #(.OFF_W(OFF_W)) u_align (
    .off_i      (lane_off),
    .size_i     (req_size),
    .misalign_o (misalign)
  );

  lx_lane_sel #(.BYTES(BYTES), .OFF_W(OFF_W)) u_lane (
    .data_i (mem_data),
    .off_i  (lane_off),
    .data_o (shifted)
  );

  lx_size_mask #(.BYTES(BYTES)) u_mask (
    .data_i (shifted),
    .size_i (req_size),
    .err_i  (misalign),
    .data_o (justified)
  );

  // Next-state logic
  always_comb begin
    valid_d = req_valid;
    load_en = req_valid;
    lo_d    = justified[REG_W-1:0];
    hi_d    = justified[MEM_W-1:REG_W];
    err_d   = misalign;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rsp_valid <= 1'b0;
    end else begin
      rsp_valid <= valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rsp_lo  <= '0;
      rsp_hi  <= '0;
      rsp_err <= 1'b0;
    end else if (load_en) begin
      rsp_lo  <= lo_d;
      rsp_hi  <= hi_d;
      rsp_err <= err_d;
    end
  end

  // R2
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    req_valid |=> rsp_valid);

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !req_valid |=> (!rsp_valid && $stable(rsp_lo) && $stable(rsp_hi) && $stable(rsp_err)));

  // R8
  err_zero_data_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rsp_err |-> (rsp_lo == '0 && rsp_hi == '0));

  // R7
  narrow_hi_zero_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && req_size != SZ_DBL) |=> (rsp_hi == '0));

  // R3
  byte_zext_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && req_size == SZ_BYTE) |=> (rsp_lo[REG_W-1:8] == '0));

  // R4
  half_zext_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && req_size == SZ_HALF) |=> (rsp_lo[REG_W-1:16] == '0));

  // R6
  dbl_aligned_ok_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && req_size == SZ_DBL && lane_off == '0) |=> (!rsp_err && {rsp_hi, rsp_lo} == $past(mem_data)));
endmodule

// File: tb/lx_load_extract_test.sv
`timescale 1ns/1ps
module lx_load_extract_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [31:0] req_addr;
  logic [1:0]  req_size;
  logic [63:0] mem_data;
  logic        rsp_valid;
  logic [31:0] rsp_lo, rsp_hi;
  logic        rsp_err;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  logic        exp_valid;
  logic [31:0] exp_lo, exp_hi;
  logic        exp_err;

  always #5 clk = ~clk;

  lx_load_extract uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_size(req_size), .mem_data(mem_data), .rsp_valid(rsp_valid),
    .rsp_lo(rsp_lo), .rsp_hi(rsp_hi), .rsp_err(rsp_err)
  );

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_clear();
    exp_valid = 0; exp_lo = 0; exp_hi = 0; exp_err = 0;
  endtask

  task automatic compare_all();
    check("R2 rsp_valid", 64'(rsp_valid), 64'(exp_valid));
    check("R8 rsp_err",   64'(rsp_err),   64'(exp_err));
    check("R3 rsp_lo",    64'(rsp_lo),    64'(exp_lo));
    check("R7 rsp_hi",    64'(rsp_hi),    64'(exp_hi));
  endtask

  // Behavioural reference: gather bytes from a lane list, little-endian.
  task automatic model_step(bit v, logic [31:0] a, logic [1:0] s, logic [63:0] d);
    int nbytes;
    int off;
    logic [63:0] val;
    exp_valid = v;
    if (v) begin
      nbytes = 1 << s;
      off = int'(a[2:0]);
      val = '0;
      exp_err = (off % nbytes) != 0;
      if (!exp_err) begin
        for (int i = 0; i < nbytes; i++) val[8*i +: 8] = d[8*(off+i) +: 8];
      end
      exp_lo = val[31:0];
      exp_hi = val[63:32];
    end
  endtask

  // Drive at negedge, check just after the capturing edge, return to negedge.
  task automatic apply(bit v, logic [31:0] a, logic [1:0] s, logic [63:0] d);
    req_valid = v; req_addr = a; req_size = s; mem_data = d;
    model_step(v, a, s, d);
    @(posedge clk); #1;
    compare_all();
    @(negedge clk);
  endtask

  initial begin
    #(200_000 * 10);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic [63:0] d;
    rst_n = 0; req_valid = 0; req_addr = 0; req_size = 0; mem_data = 0;
    model_clear();
    repeat (3) @(negedge clk);
    compare_all(); // R1 during reset
    rst_n = 1;
    repeat (3) @(negedge clk);
    compare_all(); // R1 after release

    // Bytes 0x01..0x04 at addresses 4..7 in the word at address 0
    d = 64'h04030201_DEADBEEF;
    apply(1, 32'h4, 2'd0, d);
    check("R3 byte example", 64'(rsp_lo), 64'h1);
    apply(1, 32'h4, 2'd1, d);
    check("R4 half example", 64'(rsp_lo), 64'h201);
    apply(1, 32'h4, 2'd2, d);
    check("R5 word example", 64'(rsp_lo), 64'h04030201);
    check("R7 word hi zero", 64'(rsp_hi), 64'h0);
    apply(1, 32'h7, 2'd0, 64'hFF00_0000_0000_0000);
    check("R3 top lane zext", 64'(rsp_lo), 64'hFF);
    apply(1, 32'h6, 2'd1, 64'hBEEF_0000_0000_0000);
    check("R4 top half", 64'(rsp_lo), 64'hBEEF);
    // Bytes 0x01..0x08 at addresses 8..15
    apply(1, 32'h8, 2'd3, 64'h08070605_04030201);
    check("R6 dbl lo", 64'(rsp_lo), 64'h04030201);
    check("R6 dbl hi", 64'(rsp_hi), 64'h08070605);
    // Misaligned cases
    apply(1, 32'h4, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF);
    check("R8 dbl misaligned err", 64'(rsp_err), 64'h1);
    check("R8 dbl misaligned data", {rsp_hi, rsp_lo}, 64'h0);
    apply(1, 32'h3, 2'd1, 64'hFFFF_FFFF_FFFF_FFFF);
    check("R8 half odd err", 64'(rsp_err), 64'h1);
    apply(1, 32'h2, 2'd2, 64'hFFFF_FFFF_FFFF_FFFF);
    check("R8 word misaligned err", 64'(rsp_err), 64'h1);
    // Load a known result, then idle with changing inputs
    apply(1, 32'h0, 2'd3, 64'h1122334455667788);
    for (int i = 0; i < 4; i++) begin
      apply(0, 32'h5 + i, 2'(i), 64'hA5A5_5A5A_0F0F_F0F0 ^ 64'(i));
      check("R9 idle hold lo", 64'(rsp_lo), 64'h55667788);
      check("R9 idle hold hi", 64'(rsp_hi), 64'h11223344);
      check("R9 idle valid", 64'(rsp_valid), 64'h0);
    end

    // Asynchronous reset mid-run
    @(negedge clk);
    rst_n = 0; #1;
    model_clear();
    compare_all(); // R1 async clear
    @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    compare_all(); // R1

    // Exhaustive size/offset sweep, valid and idle mixed
    for (int rep = 0; rep < 40; rep++) begin
      for (int s = 0; s < 4; s++) begin
        for (int o = 0; o < 8; o++) begin
          apply(($urandom % 4) != 0, {$urandom, 3'(o)} , 2'(s), {$urandom, $urandom});
        end
      end
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule